// File: doc/BRIEF.md
# Signed Word Multiplier with Overflow and Condition Flags

This block multiplies two 32-bit signed words taken from 64-bit register values. Only the low word of each operand is used. That word is sign-extended, and the two are multiplied to a full 64-bit signed product. The destination value keeps only the low 32 bits of that product, with the upper 32 bits forced to zero. The full product is used for one purpose only: deciding whether the result overflowed the signed 32-bit range.

Two control bits are captured together with the operands. The overflow-enable bit asks for an overflow report. The record bit asks for a three-bit sign classification of the written word. The multiply is iterative: it retires a fixed number of multiplier bits per cycle, so the completion strobe arrives a fixed, parameter-derived number of cycles after the start is accepted. A start that arrives while a multiply is in progress is dropped. All outputs hold their values from one completion to the next.

Top module: `wmul_unit`

## Requirements
- R1: Each operand is the low 32 bits of its 64-bit input, read as signed. Bits 63..32 of both inputs have no effect on any output. Operands and control bits are sampled only on the cycle a start is accepted.
- R2: On completion, `result` equals the low 32 bits of the signed product in bits 31..0, and bits 63..32 of `result` are zero.
- R3: `ov_valid` is high in the completion cycle exactly when `ov_en` was set at start. `ov_flag` is then 1 exactly when the signed product lies outside -2^31..2^31-1; for example, 0x10000 times 0x10000 gives `result` 0 and `ov_flag` 1. When `ov_en` was clear, `ov_flag` is 0.
- R4: `cond_valid` is high in the completion cycle exactly when `rec_en` was set at start. `cond` is then {LT, GT, EQ} (bit 2 LT, bit 1 GT, bit 0 EQ), formed by comparing `result[31:0]` read as signed 32-bit against zero. When `rec_en` was clear, `cond` is 3'b000.
- R5: Whenever `cond_valid` is high, exactly one bit of `cond` is set.
- R6: `done` is a single-cycle pulse. It is high in the cycle that follows the LATENCY-th rising edge after the edge that accepts the start, where LATENCY = WORD_W/STEP_BITS + 1 (9 with default parameters).
- R7: `result`, `ov_flag` and `cond` change only in a completion cycle and hold their values between completions. `ov_valid` and `cond_valid` are high only together with `done`.
- R8: A start asserted while a multiply is in progress is ignored: it produces no extra `done` and does not alter the result. A start asserted in the completion cycle is accepted.
- R9: While and right after synchronous reset, `result`, `ov_flag`, `cond`, `ov_valid`, `cond_valid` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply; accepted when idle |
| src_a | input | 64 | First register value; low word is the multiplicand |
| src_b | input | 64 | Second register value; low word is the multiplier |
| ov_en | input | 1 | Request an overflow report |
| rec_en | input | 1 | Request the sign classification |
| result | output | 64 | Zero-extended low word of the product |
| ov_valid | output | 1 | Overflow report present this cycle |
| ov_flag | output | 1 | Product does not fit in signed 32 bits |
| cond_valid | output | 1 | Sign classification present this cycle |
| cond | output | 3 | {LT, GT, EQ} of the written word |
| done | output | 1 | Completion strobe |

## Verification
The hardest case to reach from the ports is a start that lands while the unit is busy, together with a start in the completion cycle itself. One is dropped and the other must be taken. The stimulus covers both. One test issues a second start a few cycles into a run with different operands, then watches two full latencies for a stray strobe or a changed result. A second test raises start on the same cycle where `done` is first seen, and checks that the next strobe arrives exactly one latency later with the new product. The overflow boundary is reached with operand pairs whose products equal +2^31 and -2^31. The first of these overflows and the second fits.

// File: rtl/wmul_pkg.sv
`timescale 1ns/1ps
package wmul_pkg;

    localparam int unsigned DEF_REG_W     = 64;
    localparam int unsigned DEF_WORD_W    = 32;
    localparam int unsigned DEF_STEP_BITS = 4;

    // Sign classification of the written word, bit 2 = lt, bit 0 = eq.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } cond_t;

    // Request options captured when a start is accepted.
    typedef struct packed {
        logic ov_en;
        logic rec_en;
    } op_ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } core_state_e;

    function automatic cond_t cond_from_word(input logic neg, input logic zero);
        cond_t c;
        c.lt = neg;
        c.gt = !neg && !zero;
        c.eq = zero;
        return c;
    endfunction

endpackage

// File: rtl/wmul_operand_prep.sv
`timescale 1ns/1ps
module wmul_operand_prep #(
    parameter int unsigned REG_W  = 64,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OUT_W  = 64
) (
    input  logic [REG_W-1:0] reg_val,
    output logic [OUT_W-1:0] op_val
);

    logic [WORD_W-1:0] word;
    logic              unused_hi;

    assign word      = reg_val[WORD_W-1:0];
    assign unused_hi = ^reg_val[REG_W-1:WORD_W];

    generate
        if (OUT_W > WORD_W) begin : g_sext
            assign op_val = {{(OUT_W-WORD_W){word[WORD_W-1]}}, word};
        end else begin : g_plain
            assign op_val = word;
        end
    endgenerate

endmodule

// File: rtl/wmul_iter_core.sv
`timescale 1ns/1ps
module wmul_iter_core
    import wmul_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned STEP_BITS = 4,
    parameter int unsigned PROD_W    = 2*WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PROD_W-1:0] mcand_in,
    input  logic [WORD_W-1:0] mplier_in,
    output logic [PROD_W-1:0] prod,
    output logic              prod_valid
);

    localparam int unsigned STEPS = WORD_W / STEP_BITS;
    localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

    core_state_e       state_q;
    logic [PROD_W-1:0] mcand_q;
    logic [WORD_W-1:0] mplier_q;
    logic [PROD_W-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              valid_q;
    logic              last_step;
    logic [PROD_W-1:0] term [STEP_BITS];
    logic [PROD_W-1:0] step_sum;

    assign last_step = (cnt_q == LAST_CNT);

    // One shifted multiplicand per multiplier bit of this step. The top
    // bit of the final step carries negative weight (two's complement).
    generate
        for (genvar j = 0; j < STEP_BITS; j++) begin : g_term
            if (j == STEP_BITS - 1) begin : g_top
                assign term[j] = !mplier_q[j] ? '0 :
                                 (last_step ? (~(mcand_q << j) + PROD_W'(1))
                                            : (mcand_q << j));
            end else begin : g_low
                assign term[j] = mplier_q[j] ? (mcand_q << j) : '0;
            end
        end
    endgenerate

    always_comb begin
        step_sum = '0;
        for (int k = 0; k < STEP_BITS; k++) begin
            step_sum = step_sum + term[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        mcand_q  <= mcand_in;
                        mplier_q <= mplier_in;
                        acc_q    <= '0;
                        cnt_q    <= '0;
                        state_q  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    acc_q    <= acc_q + step_sum;
                    mcand_q  <= mcand_q << STEP_BITS;
                    mplier_q <= mplier_q >> STEP_BITS;
                    cnt_q    <= cnt_q + CNT_W'(1);
                    if (last_step) begin
                        state_q <= ST_IDLE;
                        valid_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign prod       = acc_q;
    assign prod_valid = valid_q;

endmodule

// File: rtl/wmul_result_fmt.sv
`timescale 1ns/1ps
module wmul_result_fmt
    import wmul_pkg::*;
#(
    parameter int unsigned REG_W  = 64,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PROD_W = 2*WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_valid,
    input  logic [PROD_W-1:0] prod,
    input  op_ctl_t           ctl,
    output logic [REG_W-1:0]  result,
    output logic              ov_valid,
    output logic              ov_flag,
    output logic              cond_valid,
    output cond_t             cond,
    output logic              done
);

    logic [WORD_W-1:0]        low_word;
    logic [PROD_W-WORD_W:0]   hi_bits;
    logic                     does_not_fit;
    cond_t                    cls;

    assign low_word     = prod[WORD_W-1:0];
    // Fits in signed WORD_W bits iff bits from the word sign upward agree.
    assign hi_bits      = prod[PROD_W-1:WORD_W-1];
    assign does_not_fit = !((&hi_bits) || !(|hi_bits));
    assign cls          = cond_from_word(low_word[WORD_W-1], low_word == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            ov_valid   <= 1'b0;
            ov_flag    <= 1'b0;
            cond_valid <= 1'b0;
            cond       <= '0;
            done       <= 1'b0;
        end else begin
            done       <= prod_valid;
            ov_valid   <= prod_valid && ctl.ov_en;
            cond_valid <= prod_valid && ctl.rec_en;
            if (prod_valid) begin
                result  <= {{(REG_W-WORD_W){1'b0}}, low_word};
                ov_flag <= ctl.ov_en && does_not_fit;
                cond    <= ctl.rec_en ? cls : '0;
            end
        end
    end

endmodule

// File: rtl/wmul_unit.sv
`timescale 1ns/1ps
module wmul_unit
    import wmul_pkg::*;
#(
    parameter int unsigned REG_W     = DEF_REG_W,
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned STEP_BITS = DEF_STEP_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             ov_en,
    input  logic             rec_en,
    output logic [REG_W-1:0] result,
    output logic             ov_valid,
    output logic             ov_flag,
    output logic             cond_valid,
    output logic [2:0]       cond,
    output logic             done
);

    localparam int unsigned PROD_W  = 2 * WORD_W;
    localparam int unsigned LATENCY = WORD_W / STEP_BITS + 1;

    logic              busy_q;
    logic              accept;
    op_ctl_t           ctl_q;
    logic [PROD_W-1:0] mcand;
    logic [WORD_W-1:0] mplier;
    logic [PROD_W-1:0] prod;
    logic              prod_valid;
    cond_t             cond_s;

    assign accept = start && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ctl_q  <= '0;
        end else begin
            if (accept) begin
                busy_q       <= 1'b1;
                ctl_q.ov_en  <= ov_en;
                ctl_q.rec_en <= rec_en;
            end else if (prod_valid) begin
                busy_q <= 1'b0;
            end
        end
    end

    wmul_operand_prep #(
        .REG_W (REG_W),
        .WORD_W(WORD_W),
        .OUT_W (PROD_W)
    ) u_prep_a (
        .reg_val(src_a),
        .op_val (mcand)
    );

    wmul_operand_prep #(
        .REG_W (REG_W),
        .WORD_W(WORD_W),
        .OUT_W (WORD_W)
    ) u_prep_b (
        .reg_val(src_b),
        .op_val (mplier)
    );

    wmul_iter_core #(
        .WORD_W   (WORD_W),
        .STEP_BITS(STEP_BITS),
        .PROD_W   (PROD_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .prod      (prod),
        .prod_valid(prod_valid)
    );

    wmul_result_fmt #(
        .REG_W (REG_W),
        .WORD_W(WORD_W),
        .PROD_W(PROD_W)
    ) u_fmt (
        .clk       (clk),
        .rst       (rst),
        .prod_valid(prod_valid),
        .prod      (prod),
        .ctl       (ctl_q),
        .result    (result),
        .ov_valid  (ov_valid),
        .ov_flag   (ov_flag),
        .cond_valid(cond_valid),
        .cond      (cond_s),
        .done      (done)
    );

    assign cond = cond_s;

endmodule

// File: rtl/wmul_checker.sv
`timescale 1ns/1ps
module wmul_checker #(
    parameter int unsigned REG_W     = 64,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned STEP_BITS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [REG_W-1:0] result,
    input logic             ov_valid,
    input logic             ov_flag,
    input logic             cond_valid,
    input logic [2:0]       cond,
    input logic             done
);

    localparam int unsigned LAT   = WORD_W / STEP_BITS + 1;
    localparam int unsigned AGE_W = $clog2(LAT + 1);

    // Independent tracker of one outstanding request and its age.
    logic             outs;
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            outs <= 1'b0;
            age  <= '0;
        end else if (!outs) begin
            if (start) begin
                outs <= 1'b1;
                age  <= AGE_W'(1);
            end
        end else if (age == AGE_W'(LAT)) begin
            outs <= 1'b0;
        end else begin
            age <= age + AGE_W'(1);
        end
    end

    assert_done_timing_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(outs) && !outs));

    // R8: starts seen while outstanding are dropped, so only this completion occurs.
    assert_done_not_missed_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(outs) && !outs) |-> done);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ov_valid_with_done_R3: assert property (@(posedge clk) disable iff (rst)
        ov_valid |-> done);

    assert_ov_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !ov_valid) |-> !ov_flag);

    assert_cond_valid_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        cond_valid |-> done);

    assert_cond_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !cond_valid) |-> (cond == 3'b000));

    assert_lt_is_sign_R4: assert property (@(posedge clk) disable iff (rst)
        cond_valid |-> (cond[2] == result[WORD_W-1]));

    assert_cond_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        cond_valid |-> ($countones(cond) == 1));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (result[REG_W-1:WORD_W] == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(ov_flag) && $stable(cond)));

    assert_reset_state_R9: assert property (@(posedge clk)
        $past(rst) |-> (!done && !ov_valid && !cond_valid && result == '0
                        && !ov_flag && cond == 3'b000));

endmodule

bind wmul_unit wmul_checker #(
    .REG_W    (REG_W),
    .WORD_W   (WORD_W),
    .STEP_BITS(STEP_BITS)
) u_wmul_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .result    (result),
    .ov_valid  (ov_valid),
    .ov_flag   (ov_flag),
    .cond_valid(cond_valid),
    .cond      (cond),
    .done      (done)
);

// File: tb/test_wmul_unit.sv
`timescale 1ns/1ps
module test_wmul_unit;

    localparam int LAT        = 32 / 4 + 1;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        ov_en = 1'b0;
    logic        rec_en = 1'b0;
    logic [63:0] result;
    logic        ov_valid;
    logic        ov_flag;
    logic        cond_valid;
    logic [2:0]  cond;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wmul_unit i_wmul_unit (
        .clk(clk), .rst(rst), .start(start), .src_a(src_a), .src_b(src_b),
        .ov_en(ov_en), .rec_en(rec_en), .result(result), .ov_valid(ov_valid),
        .ov_flag(ov_flag), .cond_valid(cond_valid), .cond(cond), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected values straight from R1-style definitions: signed low words,
    // exact product, fit test, sign classification of the low word.
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input bit oe, input bit rc,
                                  output logic [63:0] r, output logic ov,
                                  output logic [2:0] c);
        logic signed [31:0] sa;
        logic signed [31:0] sb;
        logic signed [31:0] lw;
        longint p;
        sa = a[31:0];
        sb = b[31:0];
        p  = longint'(sa) * longint'(sb);
        lw = p[31:0];
        r  = {32'h0, lw};
        ov = oe && (p != longint'(lw));
        c  = rc ? {lw < 0, lw > 0, lw == 0} : 3'b000;
    endfunction

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_op(input string name, input logic [63:0] a,
                          input logic [63:0] b, input bit oe, input bit rc);
        logic [63:0] er;
        logic        eov;
        logic [2:0]  ec;
        int          cyc;
        model(a, b, oe, rc, er, eov, ec);
        @(negedge clk);
        start = 1'b1; src_a = a; src_b = b; ov_en = oe; rec_en = rc;
        @(negedge clk);
        // R1: inputs after the accepting edge must not matter
        start = 1'b0; src_a = ~a; src_b = ~b; ov_en = !oe; rec_en = !rc;
        wait_done(cyc);
        chk(cyc == LAT, "R6", {name, " latency"}, 64'(cyc), 64'(LAT));
        chk(result == er, "R2", {name, " result"}, result, er);
        chk(ov_valid == oe, "R3", {name, " ov_valid"}, 64'(ov_valid), 64'(oe));
        chk(ov_flag == eov, "R3", {name, " ov_flag"}, 64'(ov_flag), 64'(eov));
        chk(cond_valid == rc, "R4", {name, " cond_valid"}, 64'(cond_valid), 64'(rc));
        chk(cond == ec, "R4", {name, " cond"}, 64'(cond), 64'(ec));
        if (rc)
            chk($countones(cond) == 1, "R5", {name, " cond one-hot"}, 64'(cond), 64'(ec));
        @(negedge clk);
        chk(!done, "R6", {name, " done pulse width"}, 64'(done), 64'd0);
        chk(result == er, "R7", {name, " result after done"}, result, er);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result == 64'h0 && !done && !ov_valid && !cond_valid && !ov_flag
            && cond == 3'b000, "R9", "outputs after reset",
            {result[59:0], done, ov_valid, cond_valid, ov_flag}, 64'h0);
    endtask

    task automatic t_busy_start();
        logic [63:0] er;
        logic        eov;
        logic [2:0]  ec;
        int          cyc;
        int          extra;
        model(64'd6, 64'hFFFF_FFF9, 1'b1, 1'b1, er, eov, ec);
        @(negedge clk);
        start = 1'b1; src_a = 64'd6; src_b = 64'hFFFF_FFF9; ov_en = 1'b1; rec_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R8: second request while busy
        start = 1'b1; src_a = 64'h10000; src_b = 64'h10000; ov_en = 1'b0; rec_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        chk(cyc + 3 == LAT, "R8", "busy start latency", 64'(cyc + 3), 64'(LAT));
        chk(result == er, "R8", "busy start result", result, er);
        chk(cond == ec, "R8", "busy start cond", 64'(cond), 64'(ec));
        extra = 0;
        for (int i = 0; i < 2 * LAT; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R8", "no second done", 64'(extra), 64'd0);
        chk(result == er, "R7", "result held after ignored start", result, er);
    endtask

    task automatic t_back_to_back();
        logic [63:0] er1, er2;
        logic        eov;
        logic [2:0]  ec;
        int          cyc;
        model(64'd100, 64'd200, 1'b1, 1'b1, er1, eov, ec);
        model(64'hFFFF_FFFF, 64'd9, 1'b1, 1'b1, er2, eov, ec);
        @(negedge clk);
        start = 1'b1; src_a = 64'd100; src_b = 64'd200; ov_en = 1'b1; rec_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        chk(result == er1, "R2", "first of back-to-back", result, er1);
        // R8: start in the completion cycle is accepted
        start = 1'b1; src_a = 64'hFFFF_FFFF; src_b = 64'd9;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        chk(cyc == LAT, "R8", "start in done cycle latency", 64'(cyc), 64'(LAT));
        chk(result == er2, "R8", "start in done cycle result", result, er2);
        chk(cond == ec, "R4", "start in done cycle cond", 64'(cond), 64'(ec));
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [63:0] r0;
        logic        o0;
        logic [2:0]  c0;
        int          bad;
        run_op("hold_seed", 64'h7FFF_FFFF, 64'h7FFF_FFFF, 1'b1, 1'b1);
        r0 = result; o0 = ov_flag; c0 = cond;
        bad = 0;
        src_a = 64'h1234; src_b = 64'h5678;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (result != r0 || ov_flag != o0 || cond != c0 || ov_valid || cond_valid || done)
                bad++;
        end
        chk(bad == 0, "R7", "outputs hold while idle", 64'(bad), 64'd0);
    endtask

    initial begin
        #(WD_CYCLES * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        run_op("basic", 64'd3, 64'd7, 1'b1, 1'b1);
        run_op("neg", 64'hFFFF_FFF6, 64'd3, 1'b1, 1'b1);
        run_op("ex_0x10000", 64'h10000, 64'h10000, 1'b1, 1'b1);
        run_op("R1_upper_ignored", 64'hDEAD_BEEF_0000_0005, 64'h1234_5678_FFFF_FFFF, 1'b1, 1'b1);
        run_op("min_min", 64'h8000_0000, 64'h8000_0000, 1'b1, 1'b1);
        run_op("plus_2p31", 64'hFFFF_FFFF, 64'h8000_0000, 1'b1, 1'b1);
        run_op("minus_2p31", 64'h8000_0000, 64'd1, 1'b1, 1'b1);
        run_op("max_fit", 64'h7FFF_FFFF, 64'd1, 1'b1, 1'b1);
        run_op("zero", 64'd0, 64'hFFFF_1234, 1'b1, 1'b1);
        run_op("flags_off", 64'h10000, 64'h10000, 1'b0, 1'b0);
        run_op("ov_only", 64'h10000, 64'h10000, 1'b1, 1'b0);
        run_op("rec_only", 64'hFFFF_FFFE, 64'd5, 1'b0, 1'b1);
        t_busy_start();
        t_back_to_back();
        t_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule